// File: doc/BRIEF.md
# Dual Leaky Bucket Frame Policer

This block meters one traffic flow inside a packet switch and decides, frame by frame, whether each arriving frame may pass and what colour it carries. It holds two leaky buckets. The peak bucket is always active. The committed bucket is optional. Each accepted frame fills a bucket by its cost. In the byte modes the cost is the frame length, plus the inter-packet gap in line mode. In the frame modes each frame costs a fixed ten tenths of a frame. Every bucket drains by its programmed rate on periodic leak ticks.

Configuration is loaded as one word by a write strobe. Four metering modes are available: line rate, data rate, high-resolution frame rate and low-resolution frame rate. Each mode sets its own burst scaling. The word also carries the two rates, the two bursts, the gap size, the committed-bucket enable, bucket coupling and overshoot. Software can write either bucket's level directly. Forcing a level to all ones locks that bucket as permanently full. Placing the maximum peak rate with a zero burst makes the policer transparent, and that is also the reset setting.

Top module: `dlb_policer`

## Requirements
- R1: After a synchronous reset `dec_valid` is low and the configuration is data-rate mode, peak rate 65535, peak burst 0, committed bucket off, coupling off, overshoot on, gap size 20.
- R2: `dec_valid` is high in exactly the cycle after each cycle with `frm_valid` high. The decision uses the bucket levels and the configuration held before that clock edge.
- R3: Frame cost is the byte length plus the gap size in mode 0 (line), the byte length in mode 1 (data), and 10 units in modes 2 and 3 (frame rate; one unit is a tenth of a frame).
- R4: A burst value b gives a threshold of b*4096 in modes 0 and 1, b*328 in mode 2 and b*3 in mode 3.
- R5: A bucket admits a frame when its level is not all ones and, with overshoot on, its level does not exceed the threshold, or, with overshoot off, level plus cost does not exceed the threshold.
- R6: The colour codes are 0 green, 1 yellow and 2 red. `dec_pass` is 1 for green and yellow and 0 for red. A frame is green when the peak bucket admits it and the committed bucket is disabled or also admits it. It is yellow when only the peak bucket admits it, and red otherwise. With the committed bucket disabled no frame is yellow.
- R7: A green frame adds its cost to the peak bucket, and to the committed bucket when that bucket is enabled. A yellow frame adds its cost to the peak bucket only. A red frame adds nothing.
- R8: A leak tick occurs every TICK_DIV cycles, the first on the TICK_DIV-th clock edge after reset. On a tick each bucket level drops by its rate and saturates at zero. In the same cycle the drain is applied before the frame charge.
- R9: In mode 3 the buckets drain only on every LO_SLOW-th leak tick.
- R10: When coupling and the committed bucket are both on, any part of a committed drain that exceeds the committed level is added to the peak drain of the same tick.
- R11: A direct level write replaces that bucket's level and overrides any drain or charge in that cycle. A level of all ones is neither drained nor charged and fails its admission check. Charging alone never reaches all ones.
- R12: A configuration write takes effect for frames arriving from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration word |
| cfg_mode | input | 2 | Metering mode 0..3 |
| cfg_pir | input | 16 | Peak drain per tick |
| cfg_pbs | input | 7 | Peak burst value |
| cfg_cir | input | 16 | Committed drain per tick |
| cfg_cbs | input | 7 | Committed burst value |
| cfg_ipg | input | 5 | Gap bytes added in line mode |
| cfg_cir_en | input | 1 | Enable the committed bucket |
| cfg_couple | input | 1 | Pass committed overflow to peak |
| cfg_overshoot | input | 1 | Admit on level alone |
| lvl_we_peak | input | 1 | Write the peak bucket level |
| lvl_we_cmt | input | 1 | Write the committed bucket level |
| lvl_wdata | input | 23 | Level value to write |
| frm_valid | input | 1 | Frame arrival strobe |
| frm_len | input | 14 | Frame length in bytes |
| dec_valid | output | 1 | Decision strobe |
| dec_pass | output | 1 | Frame may be forwarded |
| dec_color | output | 2 | Frame colour code |

## Verification
The hardest case to reach from the ports is coupling. The committed bucket must be emptier than its rate at the moment a tick fires, while the peak bucket sits just above the point where one more frame would be refused. The stimulus reaches it by writing both levels directly and idling past a tick. It then sends a frame that is admitted only if the overflow was credited to the peak bucket, and repeats the sequence with coupling off to get the opposite result. A behavioural model of the levels, ticks and colours runs alongside every cycle, including a long stretch of randomised configurations and level writes.

// File: rtl/pol_pkg.sv
package pol_pkg;
  typedef enum logic [1:0] {
    MODE_LINE = 2'd0,
    MODE_DATA = 2'd1,
    MODE_FHI  = 2'd2,
    MODE_FLO  = 2'd3
  } pol_mode_e;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } pol_color_e;

  // level units: bytes in byte modes, tenths of a frame in frame modes
  localparam int FRAME_COST = 10;
  localparam int BYTE_SHIFT = 12;
  localparam int FHI_UNIT   = 328;
  localparam int FLO_UNIT   = 3;
endpackage

// File: rtl/pol_tick.sv
module pol_tick #(
  parameter int TICK_DIV = 1000,
  parameter int LO_SLOW  = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic slow_tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW = (LO_SLOW > 1) ? $clog2(LO_SLOW) : 1;

  logic [CW-1:0] cnt;
  logic [SW-1:0] scnt;

  assign tick      = (cnt == CW'(TICK_DIV - 1));
  assign slow_tick = tick && (scnt == SW'(LO_SLOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      scnt <= '0;
    end else if (tick) begin
      cnt  <= '0;
      scnt <= slow_tick ? '0 : scnt + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: ticks are spaced by the divider
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (TICK_DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/pol_bucket.sv
module pol_bucket #(
  parameter int STATE_W = 23,
  parameter int DRAIN_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_data,
  input  logic               drain_en,
  input  logic [DRAIN_W-1:0] drain_amt,
  input  logic               charge_en,
  input  logic [STATE_W-1:0] charge_amt,
  output logic [STATE_W-1:0] level,
  output logic [DRAIN_W-1:0] excess
);
  localparam logic [STATE_W-1:0] MAXL = {{(STATE_W-1){1'b1}}, 1'b0};

  logic               locked;
  logic [STATE_W-1:0] dx, after;
  logic [STATE_W:0]   sum;
  logic [STATE_W-1:0] nxt;

  assign locked = &level;
  assign dx     = STATE_W'(drain_amt);

  always_comb begin
    if (drain_en) after = (dx >= level) ? '0 : level - dx;
    else          after = level;
    sum = {1'b0, after} + {1'b0, (charge_en ? charge_amt : '0)};
    nxt = (sum > {1'b0, MAXL}) ? MAXL : sum[STATE_W-1:0];
    if (drain_en && !locked && dx > level) excess = DRAIN_W'(dx - level);
    else                                   excess = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          level <= '0;
    else if (wr_en)   level <= wr_data;
    else if (!locked) level <= nxt;
  end

  // R11: a locked bucket stays locked until written
  a_r11_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (locked && !wr_en) |=> (&level));
  // R11: charging never produces the lock value
  a_r11_no_self_lock: assert property (@(posedge clk) disable iff (rst)
    (!locked && !wr_en) |=> !(&level));
  // R8: without charge or write, a level never rises
  a_r8_drain_monotone: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !charge_en) |=> (level <= $past(level)));
endmodule

// File: rtl/dlb_policer.sv
module dlb_policer
  import pol_pkg::*;
#(
  parameter int LEN_W    = 14,
  parameter int RATE_W   = 16,
  parameter int BURST_W  = 7,
  parameter int IPG_W    = 5,
  parameter int STATE_W  = 23,
  parameter int TICK_DIV = 1000,
  parameter int LO_SLOW  = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_mode,
  input  logic [RATE_W-1:0]  cfg_pir,
  input  logic [BURST_W-1:0] cfg_pbs,
  input  logic [RATE_W-1:0]  cfg_cir,
  input  logic [BURST_W-1:0] cfg_cbs,
  input  logic [IPG_W-1:0]   cfg_ipg,
  input  logic               cfg_cir_en,
  input  logic               cfg_couple,
  input  logic               cfg_overshoot,
  input  logic               lvl_we_peak,
  input  logic               lvl_we_cmt,
  input  logic [STATE_W-1:0] lvl_wdata,
  input  logic               frm_valid,
  input  logic [LEN_W-1:0]   frm_len,
  output logic               dec_valid,
  output logic               dec_pass,
  output logic [1:0]         dec_color
);
  localparam int DRAIN_W = RATE_W + 1;

  pol_mode_e          mode_q;
  logic [RATE_W-1:0]  pir_q, cir_q;
  logic [BURST_W-1:0] pbs_q, cbs_q;
  logic [IPG_W-1:0]   ipg_q;
  logic               cir_en_q, couple_q, ovs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_DATA;
      pir_q    <= '1;
      pbs_q    <= '0;
      cir_q    <= '0;
      cbs_q    <= '0;
      ipg_q    <= IPG_W'(20);
      cir_en_q <= 1'b0;
      couple_q <= 1'b0;
      ovs_q    <= 1'b1;
    end else if (cfg_we) begin
      mode_q   <= pol_mode_e'(cfg_mode);
      pir_q    <= cfg_pir;
      pbs_q    <= cfg_pbs;
      cir_q    <= cfg_cir;
      cbs_q    <= cfg_cbs;
      ipg_q    <= cfg_ipg;
      cir_en_q <= cfg_cir_en;
      couple_q <= cfg_couple;
      ovs_q    <= cfg_overshoot;
    end
  end

  function automatic logic [STATE_W-1:0] thr_of(input pol_mode_e m,
                                                input logic [BURST_W-1:0] b);
    case (m)
      MODE_LINE, MODE_DATA: return STATE_W'(b) << BYTE_SHIFT;
      MODE_FHI:             return STATE_W'(b) * STATE_W'(FHI_UNIT);
      default:              return STATE_W'(b) * STATE_W'(FLO_UNIT);
    endcase
  endfunction

  function automatic logic fits(input logic [STATE_W-1:0] lvl,
                                input logic [STATE_W-1:0] thr,
                                input logic [STATE_W-1:0] c,
                                input logic               ovs);
    logic [STATE_W:0] s;
    s = {1'b0, lvl} + {1'b0, c};
    if (&lvl)     return 1'b0;
    else if (ovs) return lvl <= thr;
    else          return s <= {1'b0, thr};
  endfunction

  logic tick, slow_tick, drain_en;

  pol_tick #(.TICK_DIV(TICK_DIV), .LO_SLOW(LO_SLOW)) u_tick (
    .clk(clk), .rst(rst), .tick(tick), .slow_tick(slow_tick)
  );

  assign drain_en = (mode_q == MODE_FLO) ? slow_tick : tick;

  logic [STATE_W-1:0] cost, p_lvl, c_lvl;
  logic               p_ok, c_ok, green, yellow;
  logic [DRAIN_W-1:0] c_excess, p_drain;

  always_comb begin
    case (mode_q)
      MODE_LINE: cost = STATE_W'(frm_len) + STATE_W'(ipg_q);
      MODE_DATA: cost = STATE_W'(frm_len);
      default:   cost = STATE_W'(FRAME_COST);
    endcase
    p_ok    = fits(p_lvl, thr_of(mode_q, pbs_q), cost, ovs_q);
    c_ok    = fits(c_lvl, thr_of(mode_q, cbs_q), cost, ovs_q);
    green   = p_ok && (!cir_en_q || c_ok);
    yellow  = p_ok && cir_en_q && !c_ok;
    p_drain = DRAIN_W'(pir_q) + ((couple_q && cir_en_q) ? c_excess : '0);
  end

  pol_bucket #(.STATE_W(STATE_W), .DRAIN_W(DRAIN_W)) u_cmt (
    .clk(clk), .rst(rst),
    .wr_en(lvl_we_cmt), .wr_data(lvl_wdata),
    .drain_en(drain_en), .drain_amt(DRAIN_W'(cir_q)),
    .charge_en(frm_valid && green && cir_en_q), .charge_amt(cost),
    .level(c_lvl), .excess(c_excess)
  );

  logic [DRAIN_W-1:0] p_excess_unused;

  pol_bucket #(.STATE_W(STATE_W), .DRAIN_W(DRAIN_W)) u_peak (
    .clk(clk), .rst(rst),
    .wr_en(lvl_we_peak), .wr_data(lvl_wdata),
    .drain_en(drain_en), .drain_amt(p_drain),
    .charge_en(frm_valid && p_ok), .charge_amt(cost),
    .level(p_lvl), .excess(p_excess_unused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
      dec_color <= COL_RED;
    end else begin
      dec_valid <= frm_valid;
      dec_pass  <= frm_valid && p_ok;
      dec_color <= green ? COL_GREEN : (yellow ? COL_YELLOW : COL_RED);
    end
  end

  // R2: one decision per frame, one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_valid);
  // R6: no yellow with the committed bucket off
  a_r6_no_yellow: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !cir_en_q) |=> (dec_color != COL_YELLOW));
  // R6: legal colour code consistent with pass
  a_r6_color_code: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_color != 2'd3 && ((dec_color == COL_RED) == !dec_pass)));
  // R11: a locked peak bucket refuses the frame
  a_r11_locked_peak_red: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && (&p_lvl)) |=> !dec_pass);
endmodule

// File: tb/tb_dlb_policer.sv
module tb_dlb_policer;
  localparam int TD = 5;
  localparam int LS = 3;
  localparam longint LOCK = (64'd1 << 23) - 1;
  localparam longint MAXL = LOCK - 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 0;
  logic [1:0]  cfg_mode = 0;
  logic [15:0] cfg_pir = 0, cfg_cir = 0;
  logic [6:0]  cfg_pbs = 0, cfg_cbs = 0;
  logic [4:0]  cfg_ipg = 0;
  logic        cfg_cir_en = 0, cfg_couple = 0, cfg_overshoot = 0;
  logic        lvl_we_peak = 0, lvl_we_cmt = 0;
  logic [22:0] lvl_wdata = 0;
  logic        frm_valid = 0;
  logic [13:0] frm_len = 0;
  logic        dec_valid, dec_pass;
  logic [1:0]  dec_color;

  always #4 clk = ~clk;

  dlb_policer #(.TICK_DIV(TD), .LO_SLOW(LS)) dut (.*);

  int n_tests = 0, n_fail = 0;
  string cur_req = "R2";

  // reference model state
  longint pl, cl;
  int pc, lc;
  int m_mode, m_pir, m_pbs, m_cir, m_cbs, m_ipg, m_cen, m_cpl, m_ovs;
  int e_v, e_p, e_c;

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint thr(int b);
    if (m_mode < 2) return longint'(b) * 4096;
    if (m_mode == 2) return longint'(b) * 328;
    return longint'(b) * 3;
  endfunction

  function automatic int admits(longint lvl, longint t, longint c);
    if (lvl == LOCK) return 0;
    if (m_ovs != 0) return (lvl <= t) ? 1 : 0;
    return (lvl + c <= t) ? 1 : 0;
  endfunction

  task automatic model_step();
    int tick, slow, de, pok, cok, green, yellow;
    longint cost, ex, d, na;
    tick = (pc == TD - 1);
    slow = tick && (lc == LS - 1);
    de   = (m_mode == 3) ? slow : tick;
    cost = (m_mode == 0) ? longint'(frm_len) + m_ipg :
           (m_mode == 1) ? longint'(frm_len) : 10;
    pok    = admits(pl, thr(m_pbs), cost);
    cok    = admits(cl, thr(m_cbs), cost);
    green  = pok && (!m_cen || cok);
    yellow = pok && m_cen && !cok;
    e_v = frm_valid;
    e_p = pok;
    e_c = green ? 0 : (yellow ? 1 : 2);
    ex = 0;
    if (cl != LOCK) begin
      if (de && m_cir > cl) ex = m_cir - cl;
      na = de ? ((m_cir >= cl) ? 0 : cl - m_cir) : cl;
      if (frm_valid && green && m_cen) na += cost;
      cl = (na > MAXL) ? MAXL : na;
    end
    if (pl != LOCK) begin
      d  = m_pir + ((m_cpl && m_cen) ? ex : 0);
      na = de ? ((d >= pl) ? 0 : pl - d) : pl;
      if (frm_valid && pok) na += cost;
      pl = (na > MAXL) ? MAXL : na;
    end
    if (lvl_we_cmt)  cl = lvl_wdata;
    if (lvl_we_peak) pl = lvl_wdata;
    if (cfg_we) begin
      m_mode = cfg_mode; m_pir = cfg_pir; m_pbs = cfg_pbs; m_cir = cfg_cir;
      m_cbs = cfg_cbs; m_ipg = cfg_ipg; m_cen = cfg_cir_en;
      m_cpl = cfg_couple; m_ovs = cfg_overshoot;
    end
    if (tick) begin
      pc = 0;
      lc = slow ? 0 : lc + 1;
    end else pc++;
  endtask

  // one clock: model, edge, compare at the falling edge
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (dec_valid !== e_v[0] ||
        (e_v != 0 && (dec_pass !== e_p[0] || dec_color !== e_c[1:0]))) begin
      n_fail++;
      $display("FAIL %s: actual v%0b p%0b c%0d expected v%0d p%0d c%0d",
               cur_req, dec_valid, dec_pass, dec_color, e_v, e_p, e_c);
    end
    cfg_we = 0; lvl_we_peak = 0; lvl_we_cmt = 0; frm_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send(int len);
    frm_valid = 1; frm_len = 14'(len);
    cyc();
  endtask

  task automatic setcfg(int mode, int pir, int pbs, int cir, int cbs, int ipg,
                        int cen, int cpl, int ovs);
    cfg_we = 1; cfg_mode = 2'(mode); cfg_pir = 16'(pir); cfg_pbs = 7'(pbs);
    cfg_cir = 16'(cir); cfg_cbs = 7'(cbs); cfg_ipg = 5'(ipg);
    cfg_cir_en = cen[0]; cfg_couple = cpl[0]; cfg_overshoot = ovs[0];
  endtask

  task automatic wrlvl(int peak, int cmt, longint val);
    lvl_we_peak = peak[0]; lvl_we_cmt = cmt[0]; lvl_wdata = 23'(val);
  endtask

  task automatic zero_levels();
    wrlvl(1, 1, 0); cyc();
  endtask

  bit done = 0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    pl = 0; cl = 0; pc = 0; lc = 0;
    m_mode = 1; m_pir = 65535; m_pbs = 0; m_cir = 0; m_cbs = 0; m_ipg = 20;
    m_cen = 0; m_cpl = 0; m_ovs = 1;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1", dec_valid, 0);

    // R1: transparent reset configuration, frames spaced past a tick
    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      send(1500);
      check("R1", dec_color, 0);
      idle(TD);
    end
    cur_req = "R2";
    idle(1);
    check("R2", dec_valid, 0);
    send(64);
    check("R2", dec_valid, 1);

    // R12: same-cycle configuration write does not affect that frame
    cur_req = "R12";
    zero_levels();
    setcfg(1, 0, 0, 0, 0, 20, 0, 0, 0);
    send(100);
    check("R12", dec_pass, 1);
    send(100);
    check("R12", dec_pass, 0);

    // R5: overshoot off vs on, data mode, burst 4096, no drain
    cur_req = "R5";
    setcfg(1, 0, 1, 0, 0, 20, 0, 0, 0); cyc();
    zero_levels();
    send(1500); send(1500); send(1500);
    check("R5", dec_color, 2);
    setcfg(1, 0, 1, 0, 0, 20, 0, 0, 1); cyc();
    zero_levels();
    send(1500); send(1500); send(1500);
    check("R5", dec_pass, 1);
    send(1500);
    check("R5", dec_pass, 0);

    // R3: line mode adds the gap, data mode does not
    cur_req = "R3";
    setcfg(0, 0, 1, 0, 0, 20, 0, 0, 0); cyc();
    zero_levels();
    send(2038); send(2038);
    check("R3", dec_pass, 0);
    setcfg(1, 0, 1, 0, 0, 20, 0, 0, 0); cyc();
    zero_levels();
    send(2038); send(2038);
    check("R3", dec_pass, 1);

    // R4: high frame mode, burst 1 holds 32 frames of cost 10
    cur_req = "R4";
    setcfg(2, 0, 1, 0, 0, 20, 0, 0, 0); cyc();
    zero_levels();
    for (int i = 0; i < 32; i++) send(64);
    check("R4", dec_pass, 1);
    send(64);
    check("R4", dec_pass, 0);

    // R6 / R7: committed bucket colours and charging
    cur_req = "R6";
    setcfg(1, 0, 2, 0, 1, 20, 1, 0, 0); cyc();
    zero_levels();
    send(3000);
    check("R6", dec_color, 0);
    send(3000);
    check("R6", dec_color, 1);
    cur_req = "R7";
    send(3000);
    check("R7", dec_color, 2);
    send(2000);
    check("R7", dec_color, 1);

    // R8: drain restores admission after a tick
    cur_req = "R8";
    setcfg(1, 8192, 1, 0, 0, 20, 0, 0, 0); cyc();
    wrlvl(1, 0, 4000); cyc();
    send(1000);
    check("R8", dec_pass, 0);
    idle(TD + 1);
    send(1000);
    check("R8", dec_pass, 1);

    // R9: low frame mode drains only on slow ticks
    cur_req = "R9";
    setcfg(3, 10, 1, 0, 0, 20, 0, 0, 1); cyc();
    zero_levels();
    send(64);
    check("R9", dec_pass, 1);
    send(64);
    check("R9", dec_pass, 0);
    idle(TD * LS + 1);
    send(64);
    check("R9", dec_pass, 1);
    for (int i = 0; i < 40; i++) begin send(64); idle(2); end

    // R10: coupled overflow speeds up the peak drain
    cur_req = "R10";
    setcfg(1, 0, 2, 1000, 10, 20, 1, 1, 0); cyc();
    wrlvl(1, 0, 7500); cyc();
    wrlvl(0, 1, 0); cyc();
    idle(TD + 1);
    send(1000);
    check("R10", dec_pass, 1);
    setcfg(1, 0, 2, 1000, 10, 20, 1, 0, 0); cyc();
    wrlvl(1, 0, 7500); cyc();
    wrlvl(0, 1, 0); cyc();
    idle(TD + 1);
    send(1000);
    check("R10", dec_pass, 0);

    // R11: forced full peak bucket refuses everything
    cur_req = "R11";
    setcfg(1, 65535, 127, 0, 0, 20, 0, 0, 1); cyc();
    wrlvl(1, 0, LOCK); cyc();
    idle(3 * TD);
    send(64);
    check("R11", dec_color, 2);
    send(64);
    check("R11", dec_pass, 0);
    wrlvl(1, 0, 0); cyc();
    send(64);
    check("R11", dec_pass, 1);
    setcfg(1, 0, 1, 0, 1, 20, 1, 0, 1); cyc();
    zero_levels();
    wrlvl(0, 1, LOCK); cyc();
    send(64);
    check("R11", dec_color, 1);

    // randomised stream against the model
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0)
        setcfg($urandom_range(3), $urandom_range(3000), $urandom_range(127),
               $urandom_range(3000), $urandom_range(127), $urandom_range(31),
               $urandom_range(1), $urandom_range(1), $urandom_range(1));
      if ($urandom_range(99) == 0) wrlvl($urandom_range(1), $urandom_range(1),
                                         $urandom_range(1) ? LOCK : $urandom_range(200000));
      if ($urandom_range(2) == 0) begin
        frm_valid = 1; frm_len = 14'($urandom_range(64, 9000));
      end
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule